// File: doc/BRIEF.md
# Privilege Mode and Abort Controller

This block holds the single privilege bit of a small 8-bit-class processor core. The bit is either supervisor mode, which has every privilege, or user mode, which is restricted. The core's decoder presents one strobe per instruction together with a class code and a user-memory prefix flag. The block answers with an abort request whenever a user-mode program attempts a protected operation. Because protected operations trap instead of misbehaving, a supervisor program can itself run in user mode under an emulating monitor.

The bit is set on reset and on any exception entry, meaning interrupts, traps and aborts. The jump-to-user instruction clears it. The two return instructions restore it from the mode bit that the core pops out of the extended status byte of the stack frame. That byte is driven by the block and holds the prior mode bit. The block also drives two select lines for every bus access. One picks the supervisor or the user stack pointer. The other picks the supervisor or the user memory-context code, and a supervisor instruction carrying the prefix flag overrides it for its data accesses.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset, mode_super is 1, stack_super is 1, abort_req is 0, ctx_code equals sup_ctx, and ext_status is all zero.
- R2: An accepted strobe of class ENTRY (code 1) sets mode_super at the next clock edge. At that edge, ext_status bit MODE_BIT (default 7) takes the mode held before the strobe, and every other ext_status bit stays 0.
- R3: A strobe of class JPU (code 2) issued in supervisor mode keeps mode_super, stack_super and the supervisor context during its own cycle, and clears mode_super at the next edge.
- R4: In user mode, a strobe of class JPU (2), RTU (4) or CFG (5) raises abort_req for exactly one cycle after the edge. That edge also sets mode_super and writes the prior mode (0) into ext_status bit MODE_BIT. The same classes in supervisor mode raise no abort.
- R5: A strobe of class RTI (3) is legal in user mode. On the following ret_commit, a pop_mode of 0 leaves user mode with no abort, and a pop_mode of 1 raises an abort instead of entering supervisor mode.
- R6: After an RTI (3) or RTU (4) strobe accepted in supervisor mode, the next ret_commit loads mode_super from pop_mode.
- R7: In user mode, any strobe with user_prefix set aborts as in R4, whatever its class. In supervisor mode, user_prefix together with data_access drives ctx_user high and ctx_code to usr_ctx while stack_super stays 1.
- R8: Without the prefix override, ctx_code is usr_ctx in user mode and sup_ctx in supervisor mode, and stack_super equals mode_super.
- R9: A ret_commit with no accepted return instruction pending changes nothing and raises no abort.
- R10: An abort wins over any mode change in the same cycle. When a protected strobe aborts in the same cycle as a pending return commit, the result is supervisor mode with the abort, the pending return is dropped, and a later ret_commit is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | One-cycle instruction strobe |
| instr_class | input | 3 | Class: 0 other, 1 entry, 2 jump-to-user, 3 return-from-interrupt, 4 return-from-trap, 5 config access |
| user_prefix | input | 1 | User-memory prefix flag of the current instruction |
| data_access | input | 1 | Current bus access is an operand data access |
| ret_commit | input | 1 | Stack frame of a return has been popped |
| pop_mode | input | 1 | Mode bit popped from the extended status byte |
| sup_ctx | input | CTX_W | Supervisor memory-context code |
| usr_ctx | input | CTX_W | User memory-context code |
| abort_req | output | 1 | Abort request, one cycle |
| mode_super | output | 1 | Current mode, 1 is supervisor |
| stack_super | output | 1 | 1 selects the supervisor stack pointer |
| ctx_user | output | 1 | 1 selects the user memory context |
| ctx_code | output | CTX_W | Active memory-context code |
| ext_status | output | ST_W | Extended status byte for the pushed frame |

## Verification
The functions that can share a cycle are the abort of a protected user-mode strobe and the commit of a return that is already pending. To provoke the collision, the bench accepts a user-mode RTI, then presents a config-access strobe in the same cycle as ret_commit with pop_mode 0. The outcome passes only if the abort is raised, the mode is supervisor, the saved prior mode is 0, and a further ret_commit issued back in user mode leaves the mode untouched. The sequence also pairs a jump-to-user strobe with the supervisor context that its own cycle must still show.

// File: rtl/priv_pkg.sv
package priv_pkg;
   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_OTHER = 3'd0,
      CLS_ENTRY = 3'd1,
      CLS_JPU   = 3'd2,
      CLS_RTI   = 3'd3,
      CLS_RTU   = 3'd4,
      CLS_CFG   = 3'd5
   } instr_cls_e;
endpackage

// File: rtl/priv_guard.sv
module priv_guard (
   input  logic                       instr_valid,
   input  logic [priv_pkg::CLS_W-1:0] instr_class,
   input  logic                       user_prefix,
   input  logic                       ret_commit,
   input  logic                       pop_mode,
   input  logic                       mode_q,
   input  logic                       pend_q,
   output logic                       abort_now,
   output logic                       entry_now,
   output logic                       jpu_now,
   output logic                       ret_start,
   output logic                       commit_now
);
   import priv_pkg::*;

   instr_cls_e cls;
   logic       protected_op;
   logic       abort_strobe;
   logic       abort_commit;

   always_comb begin
      cls          = instr_cls_e'(instr_class);
      protected_op = user_prefix || cls == CLS_JPU || cls == CLS_RTU || cls == CLS_CFG;
      abort_strobe = instr_valid && !mode_q && protected_op;
      commit_now   = ret_commit && pend_q;
      abort_commit = commit_now && !mode_q && pop_mode;
      abort_now    = abort_strobe || abort_commit;
      entry_now    = instr_valid && cls == CLS_ENTRY;
      jpu_now      = instr_valid && cls == CLS_JPU;
      ret_start    = instr_valid && (cls == CLS_RTI || cls == CLS_RTU);
   end
endmodule

// File: rtl/priv_mode_reg.sv
module priv_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic abort_now,
   input  logic entry_now,
   input  logic jpu_now,
   input  logic ret_start,
   input  logic commit_now,
   input  logic pop_mode,
   output logic mode_q,
   output logic pend_q,
   output logic prior_q,
   output logic abort_q
);
   logic mode_n;
   logic pend_n;
   logic prior_n;

   always_comb begin
      mode_n  = mode_q;
      pend_n  = pend_q;
      prior_n = prior_q;
      if (commit_now) begin
         mode_n = pop_mode;
         pend_n = 1'b0;
      end
      if (jpu_now) mode_n = 1'b0;
      if (ret_start) pend_n = 1'b1;
      if (entry_now || abort_now) begin
         mode_n  = 1'b1;
         prior_n = mode_q;
         pend_n  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 1'b1;
         pend_q  <= 1'b0;
         prior_q <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         mode_q  <= mode_n;
         pend_q  <= pend_n;
         prior_q <= prior_n;
         abort_q <= abort_now;
      end
   end
endmodule

// File: rtl/priv_bus_sel.sv
module priv_bus_sel #(
   parameter int CTX_W = 4
) (
   input  logic             mode_q,
   input  logic             user_prefix,
   input  logic             data_access,
   input  logic [CTX_W-1:0] sup_ctx,
   input  logic [CTX_W-1:0] usr_ctx,
   output logic             stack_super,
   output logic             ctx_user,
   output logic [CTX_W-1:0] ctx_code
);
   assign stack_super = mode_q;
   assign ctx_user    = !mode_q || (user_prefix && data_access);

   for (genvar b = 0; b < CTX_W; b++) begin : g_ctx
      assign ctx_code[b] = ctx_user ? usr_ctx[b] : sup_ctx[b];
   end
endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl #(
   parameter int CTX_W    = 4,
   parameter int ST_W     = 8,
   parameter int MODE_BIT = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       instr_valid,
   input  logic [priv_pkg::CLS_W-1:0] instr_class,
   input  logic                       user_prefix,
   input  logic                       data_access,
   input  logic                       ret_commit,
   input  logic                       pop_mode,
   input  logic [CTX_W-1:0]           sup_ctx,
   input  logic [CTX_W-1:0]           usr_ctx,
   output logic                       abort_req,
   output logic                       mode_super,
   output logic                       stack_super,
   output logic                       ctx_user,
   output logic [CTX_W-1:0]           ctx_code,
   output logic [ST_W-1:0]            ext_status
);
   if (CTX_W < 1) begin : g_bad_ctx
      $fatal(1, "CTX_W must be at least 1");
   end
   if (MODE_BIT < 0 || MODE_BIT >= ST_W) begin : g_bad_bit
      $fatal(1, "MODE_BIT must lie inside the status byte");
   end

   logic abort_now, entry_now, jpu_now, ret_start, commit_now;
   logic mode_q, pend_q, prior_q, abort_q;

   priv_guard u_guard (
      .instr_valid (instr_valid),
      .instr_class (instr_class),
      .user_prefix (user_prefix),
      .ret_commit  (ret_commit),
      .pop_mode    (pop_mode),
      .mode_q      (mode_q),
      .pend_q      (pend_q),
      .abort_now   (abort_now),
      .entry_now   (entry_now),
      .jpu_now     (jpu_now),
      .ret_start   (ret_start),
      .commit_now  (commit_now)
   );

   priv_mode_reg u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort_now  (abort_now),
      .entry_now  (entry_now),
      .jpu_now    (jpu_now),
      .ret_start  (ret_start),
      .commit_now (commit_now),
      .pop_mode   (pop_mode),
      .mode_q     (mode_q),
      .pend_q     (pend_q),
      .prior_q    (prior_q),
      .abort_q    (abort_q)
   );

   priv_bus_sel #(.CTX_W(CTX_W)) u_sel (
      .mode_q      (mode_q),
      .user_prefix (user_prefix),
      .data_access (data_access),
      .sup_ctx     (sup_ctx),
      .usr_ctx     (usr_ctx),
      .stack_super (stack_super),
      .ctx_user    (ctx_user),
      .ctx_code    (ctx_code)
   );

   assign abort_req  = abort_q;
   assign mode_super = mode_q;

   for (genvar i = 0; i < ST_W; i++) begin : g_ext
      if (i == MODE_BIT) begin : g_mode
         assign ext_status[i] = prior_q;
      end else begin : g_zero
         assign ext_status[i] = 1'b0;
      end
   end
endmodule

// File: rtl/priv_mode_chk.sv
module priv_mode_chk #(
   parameter int CTX_W    = 4,
   parameter int ST_W     = 8,
   parameter int MODE_BIT = 7
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       instr_valid,
   input logic [priv_pkg::CLS_W-1:0] instr_class,
   input logic                       user_prefix,
   input logic                       data_access,
   input logic [CTX_W-1:0]           usr_ctx,
   input logic                       abort_req,
   input logic                       mode_super,
   input logic                       stack_super,
   input logic                       ctx_user,
   input logic [CTX_W-1:0]           ctx_code,
   input logic [ST_W-1:0]            ext_status
);
   logic is_entry, is_jpu, is_prot;
   assign is_entry = instr_class == 3'd1;
   assign is_jpu   = instr_class == 3'd2;
   assign is_prot  = instr_class == 3'd2 || instr_class == 3'd4 || instr_class == 3'd5;

   AST_ENTRY_SETS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && is_entry |=> mode_super); // R2

   AST_ENTRY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && is_entry && (mode_super || !user_prefix)
      |=> ext_status[MODE_BIT] == $past(mode_super)); // R2

   AST_JPU_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && is_jpu && mode_super |=> !mode_super); // R3

   AST_USER_PROT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && !mode_super && (is_prot || user_prefix) |=> abort_req && mode_super); // R4

   AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |=> !abort_req); // R4

   AST_PREFIX_CTX: assert property (@(posedge clk) disable iff (!rst_n)
      mode_super && user_prefix && data_access |-> ctx_user && stack_super); // R7

   AST_USER_CTX: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_super |-> ctx_code == usr_ctx && !stack_super); // R8
endmodule

bind priv_mode_ctrl priv_mode_chk #(.CTX_W(CTX_W), .ST_W(ST_W), .MODE_BIT(MODE_BIT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr_class (instr_class),
   .user_prefix (user_prefix),
   .data_access (data_access),
   .usr_ctx     (usr_ctx),
   .abort_req   (abort_req),
   .mode_super  (mode_super),
   .stack_super (stack_super),
   .ctx_user    (ctx_user),
   .ctx_code    (ctx_code),
   .ext_status  (ext_status)
);

// File: tb/tb_priv_mode_ctrl.sv
module tb_priv_mode_ctrl;
   localparam int CTX_W = 4;
   localparam int ST_W = 8;
   localparam int MODE_BIT = 7;
   localparam logic [2:0] C_OTH = 3'd0, C_ENT = 3'd1, C_JPU = 3'd2,
                          C_RTI = 3'd3, C_RTU = 3'd4, C_CFG = 3'd5;
   localparam logic [CTX_W-1:0] SUP = 4'hA, USR = 4'h5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic instr_valid = 1'b0;
   logic [2:0] instr_class = 3'd0;
   logic user_prefix = 1'b0, data_access = 1'b0, ret_commit = 1'b0, pop_mode = 1'b0;
   logic [CTX_W-1:0] sup_ctx = SUP, usr_ctx = USR;
   logic abort_req, mode_super, stack_super, ctx_user;
   logic [CTX_W-1:0] ctx_code;
   logic [ST_W-1:0] ext_status;

   always #4 clk = ~clk;

   priv_mode_ctrl #(.CTX_W(CTX_W), .ST_W(ST_W), .MODE_BIT(MODE_BIT)) dut (.*);

   typedef struct {
      logic             ab;
      logic             md;
      logic             cu;
      logic [CTX_W-1:0] cc;
      logic [ST_W-1:0]  ex;
      string            tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int failures = 0;
   bit done = 0;

   task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: one expected item per clock edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, {abort_req, mode_super, stack_super, ctx_user, ctx_code, ext_status},
                {e.ab, e.md, e.md, e.cu, e.cc, e.ex});
         end
      end
   end

   // driver: apply one cycle of stimulus, push what the outputs must show after the edge
   task automatic step(input logic v, input logic [2:0] c, input logic pf, input logic da,
                       input logic rc, input logic pm, input logic eab, input logic emd,
                       input logic eprior, input string tag);
      exp_t e;
      @(negedge clk);
      instr_valid = v; instr_class = c; user_prefix = pf; data_access = da;
      ret_commit = rc; pop_mode = pm;
      e.ab  = eab;
      e.md  = emd;
      e.cu  = !emd || (pf && da);
      e.cc  = e.cu ? USR : SUP;
      e.ex  = '0;
      e.ex[MODE_BIT] = eprior;
      e.tag = tag;
      q.push_back(e);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      cmp("R1 reset state", {abort_req, mode_super, stack_super, ctx_code, ext_status},
          {1'b0, 1'b1, 1'b1, SUP, 8'h00});
      @(negedge clk) rst_n = 1'b1;

      step(1, C_OTH, 0, 0, 0, 0, 0, 1, 0, "R8 supervisor context");
      step(1, C_JPU, 0, 0, 0, 0, 0, 0, 0, "R3 jump-to-user clears mode");
      #1;
      cmp("R3 jump strobe cycle supervisor", {mode_super, stack_super, ctx_user, ctx_code},
          {1'b1, 1'b1, 1'b0, SUP});
      step(1, C_OTH, 0, 1, 0, 0, 0, 0, 0, "R8 user context");
      step(0, C_OTH, 0, 0, 1, 1, 0, 0, 0, "R9 stray commit ignored");
      step(1, C_RTI, 0, 0, 0, 0, 0, 0, 0, "R5 user RTI accepted");
      step(0, C_OTH, 0, 0, 1, 0, 0, 0, 0, "R5 user RTI pop clear");
      step(1, C_RTI, 0, 0, 0, 0, 0, 0, 0, "R5 user RTI accepted again");
      step(0, C_OTH, 0, 0, 1, 1, 1, 1, 0, "R5 user RTI pop set aborts");
      step(0, C_OTH, 0, 0, 0, 0, 0, 1, 0, "R4 abort lasts one cycle");
      step(1, C_ENT, 0, 0, 0, 0, 0, 1, 1, "R2 entry from supervisor");
      step(1, C_JPU, 0, 0, 0, 0, 0, 0, 1, "R3 back to user");
      step(1, C_ENT, 0, 0, 0, 0, 0, 1, 0, "R2 entry from user");
      step(1, C_RTU, 0, 0, 0, 0, 0, 1, 0, "R4 RTU in supervisor no abort");
      step(0, C_OTH, 0, 0, 1, 0, 0, 0, 0, "R6 RTU restores user");
      step(1, C_JPU, 0, 0, 0, 0, 1, 1, 0, "R4 JPU in user aborts");
      step(1, C_RTI, 0, 0, 0, 0, 0, 1, 0, "R6 supervisor RTI accepted");
      step(0, C_OTH, 0, 0, 1, 1, 0, 1, 0, "R6 RTI restores supervisor");
      step(1, C_JPU, 0, 0, 0, 0, 0, 0, 0, "R3 to user");
      step(1, C_CFG, 0, 0, 0, 0, 1, 1, 0, "R4 CFG in user aborts");
      step(1, C_JPU, 0, 0, 0, 0, 0, 0, 0, "R3 to user");
      step(1, C_RTU, 0, 0, 0, 0, 1, 1, 0, "R4 RTU in user aborts");
      step(1, C_JPU, 0, 0, 0, 0, 0, 0, 0, "R3 to user");
      step(1, C_OTH, 1, 1, 0, 0, 1, 1, 0, "R7 prefix in user aborts");
      step(1, C_OTH, 1, 1, 0, 0, 0, 1, 0, "R7 prefix supervisor data access");
      #1;
      cmp("R7 prefix override in strobe cycle", {stack_super, ctx_user, ctx_code},
          {1'b1, 1'b1, USR});
      step(1, C_OTH, 1, 0, 0, 0, 0, 1, 0, "R7 prefix without data access");
      step(1, C_CFG, 0, 0, 0, 0, 0, 1, 0, "R4 CFG in supervisor no abort");
      step(1, C_JPU, 0, 0, 0, 0, 0, 0, 0, "R10 to user");
      step(1, C_RTI, 0, 0, 0, 0, 0, 0, 0, "R10 pending user RTI");
      step(1, C_CFG, 0, 0, 1, 0, 1, 1, 0, "R10 abort beats commit");
      step(1, C_JPU, 0, 0, 0, 0, 0, 0, 0, "R10 to user after abort");
      step(0, C_OTH, 0, 0, 1, 1, 0, 0, 0, "R10 dropped return ignored");
      step(0, C_OTH, 0, 0, 0, 0, 0, 0, 0, "R8 idle user");

      @(negedge clk);
      instr_valid = 0; ret_commit = 0;
      while (q.size() > 0) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule